// File: doc/BRIEF.md
# Display Controller Command Queue Front-End

This block is the host-facing side of a graphics display controller. The host writes command bytes and parameter bytes through two separate write ports. Both land in one shared queue, and a ninth tag bit records which port each byte came from. A parser drains the queue one entry per clock.

A tagged entry starts a new command. Memory-write commands take their parameter count and target pointer from bit fields of the command byte itself. Every other command obtains its parameter pointer, its receive count and its read-back count from an external lookup port. Untagged entries that follow a command are placed into a parameter RAM at a moving pointer. A region-change pulse fires whenever a stored byte actually changes the RAM contents.

The host can read a status byte at any time. It reports queue state, pending read data and two raster-phase inputs. A data port returns parameter RAM bytes while a read-back is pending. A one-cycle completion pulse marks the final parameter of a plain memory-write command.

Top module: `dcq_frontend`

## Requirements
- R1: A command-port byte is queued with tag bit 8 set and a parameter-port byte with it clear, in arrival order. The parser removes one entry on every clock edge at which the queue is non-empty. A byte pushed at edge k is acted on at edge k+1, so its effects (RAM write, pulses) are visible after edge k+1.
- R2: The queue holds 16 entries. A byte is accepted only if a slot is free, where a slot vacated by a same-cycle pop counts as free. Otherwise the byte is dropped.
- R3: When both write ports fire in one cycle, the parameter byte is queued ahead of the command byte. If only one slot is free, the command byte is the one dropped.
- R4: A command byte whose bits 6:5 are 01 is a memory-write command. It points the parameter pointer at address 16 and clears the read-back count. Its bits 4:3 set the receive count: 00 gives 2, 01 gives 0, and 10 or 11 gives 1.
- R5: An untagged entry is written to the parameter RAM at the pointer only while the receive count is nonzero. The pointer then increments and the count decrements. Otherwise the byte is discarded without effect.
- R6: Storing a byte that differs from the old RAM contents raises, for one cycle, the change pulse bit of its region (address bits 4:3). Storing an equal byte raises none.
- R7: Any command that is not a memory-write command loads the pointer, the receive count and the read-back count from the lookup inputs, which respond combinationally to the `lkCode` output.
- R8: The status byte has bit 7 = 1, bit 6 = `hsyncIn`, bit 5 = `vsyncIn`, bit 2 = queue empty, bit 1 = queue full and bit 0 = read-back pending. Bits 4:3 are 0.
- R9: While the read-back count is nonzero, `rdData` shows the RAM byte at the pointer. A `rdStrobe` edge then advances the pointer and decrements the count. With no read-back pending, `rdData` is 0xFF and the strobe has no effect.
- R10: A command that sets the pointer to address 24 with a nonzero read-back count first copies cursor bytes into addresses 24..28: addr 0, addr 1, addr 2 masked to bits 1:0, then 0 and 0.
- R11: `wrDone` pulses for one cycle when the last parameter of a command with (cmd & 0xE4) == 0x20 is stored. No other command raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command byte write strobe |
| cmdData | input | 8 | Command byte |
| paramWrEn | input | 1 | Parameter byte write strobe |
| paramData | input | 8 | Parameter byte |
| rdStrobe | input | 1 | Read-back advance strobe |
| rdData | output | 8 | Read-back byte, 0xFF when nothing pending |
| statusByte | output | 8 | Status byte |
| hsyncIn | input | 1 | Horizontal sync phase |
| vsyncIn | input | 1 | Vertical sync phase |
| lkCode | output | 8 | Command code presented to the lookup |
| lkPtr | input | 5 | Looked-up parameter pointer |
| lkRecv | input | 4 | Looked-up receive count |
| lkSend | input | 4 | Looked-up read-back count |
| wrDone | output | 1 | Memory-write parameters complete pulse |
| dirtyPulse | output | 4 | Per-region change pulse |

## Verification
The hardest state to reach is a full queue, because the parser drains one entry every cycle and a single port can never get ahead of it. The stimulus drives both write ports in the same cycle for twenty cycles. This grows the queue by one entry per cycle until it holds 16, after which the surplus command bytes are dropped. The bench then stops writing and checks that the queue empties after exactly sixteen more edges, which proves that nothing beyond the capacity was kept. A same-cycle parameter and command pair is also used to confirm ordering: the parameter lands before the command takes over the pointer.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int PRAM_AW = 5;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic               pop;
    logic               ramWe;
    logic [PRAM_AW-1:0] ramAddr;
    logic [BYTE_W-1:0]  ramData;
    logic               csrCopy;
  } ctlStrobeT;
endpackage

// File: rtl/dcq_datapath.sv
module dcq_datapath
  import dcq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 16,
  parameter int REGION_SHIFT = 3,
  parameter int CSRW_BASE    = 0,
  parameter int CSRR_BASE    = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdWrEn,
  input  logic [BYTE_W-1:0]     cmdData,
  input  logic                  paramWrEn,
  input  logic [BYTE_W-1:0]     paramData,
  input  ctlStrobeT             st,
  input  logic                  pending,
  input  logic [PRAM_AW-1:0]    rdPtr,
  input  logic                  hsyncIn,
  input  logic                  vsyncIn,
  output logic [BYTE_W:0]       headEntry,
  output logic                  headValid,
  output logic [BYTE_W-1:0]     statusByte,
  output logic [BYTE_W-1:0]     rdData,
  output logic [(1<<(PRAM_AW-REGION_SHIFT))-1:0] dirtyPulse
);
  localparam int PW          = $clog2(FIFO_DEPTH);
  localparam int CW          = $clog2(FIFO_DEPTH + 1);
  localparam int PRAM_DEPTH  = 1 << PRAM_AW;
  localparam int RW          = PRAM_AW - REGION_SHIFT;

  logic [BYTE_W:0]      fifoMem [FIFO_DEPTH];
  logic [PW-1:0]        wrPtr, rdPtrQ;
  logic [CW-1:0]        count;
  logic [CW-1:0]        freeSlots;
  logic                 takeParam, takeCmd;
  logic [BYTE_W-1:0]    ram [PRAM_DEPTH];
  logic [RW-1:0]        regionIdx;

  // queue admission: parameter first, command second
  always_comb begin
    freeSlots = CW'(FIFO_DEPTH) - count + CW'(st.pop);
    takeParam = paramWrEn && (freeSlots != '0);
    takeCmd   = cmdWrEn && (freeSlots > CW'(takeParam));
  end

  always_ff @(posedge clk) begin
    if (takeParam) fifoMem[wrPtr] <= {1'b0, paramData};
    if (takeCmd)   fifoMem[wrPtr + PW'(takeParam)] <= {1'b1, cmdData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtrQ <= '0;
      count  <= '0;
    end else begin
      wrPtr  <= wrPtr + PW'(takeParam) + PW'(takeCmd);
      rdPtrQ <= rdPtrQ + PW'(st.pop);
      count  <= count + CW'(takeParam) + CW'(takeCmd) - CW'(st.pop);
    end
  end

  assign headEntry = fifoMem[rdPtrQ];
  assign headValid = (count != '0);

  // parameter RAM and region change pulses
  assign regionIdx = st.ramAddr[PRAM_AW-1:REGION_SHIFT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PRAM_DEPTH; i++) ram[i] <= '0;
      dirtyPulse <= '0;
    end else begin
      dirtyPulse <= '0;
      if (st.csrCopy) begin
        ram[CSRR_BASE+0] <= ram[CSRW_BASE+0];
        ram[CSRR_BASE+1] <= ram[CSRW_BASE+1];
        ram[CSRR_BASE+2] <= {6'b0, ram[CSRW_BASE+2][1:0]};
        ram[CSRR_BASE+3] <= '0;
        ram[CSRR_BASE+4] <= '0;
      end else if (st.ramWe) begin
        ram[st.ramAddr] <= st.ramData;
        if (ram[st.ramAddr] != st.ramData) dirtyPulse[regionIdx] <= 1'b1;
      end
    end
  end

  assign rdData = pending ? ram[rdPtr] : 8'hFF;

  always_comb begin
    statusByte    = 8'h80;
    statusByte[6] = hsyncIn;
    statusByte[5] = vsyncIn;
    statusByte[2] = (count == '0);
    statusByte[1] = (count == CW'(FIFO_DEPTH));
    statusByte[0] = pending;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(FIFO_DEPTH));
  // R1
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.pop |-> (count != '0));
  // R6
  dirty_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|dirtyPulse) |-> $past(st.ramWe));
  // R6
  dirty_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dirtyPulse));
endmodule

// File: rtl/dcq_control.sv
module dcq_control
  import dcq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int CODE_BASE = 16,
  parameter int CSRR_BASE = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BYTE_W:0]       headEntry,
  input  logic                  headValid,
  input  logic                  rdStrobe,
  input  logic [PRAM_AW-1:0]    lkPtr,
  input  logic [CNT_W-1:0]      lkRecv,
  input  logic [CNT_W-1:0]      lkSend,
  output logic [BYTE_W-1:0]     lkCode,
  output ctlStrobeT             st,
  output logic                  pending,
  output logic [PRAM_AW-1:0]    rdPtr,
  output logic                  wrDone
);
  logic [BYTE_W-1:0]  cmd, cmdNext;
  logic [PRAM_AW-1:0] ptr, ptrNext;
  logic [CNT_W-1:0]   rcv, rcvNext;
  logic [CNT_W-1:0]   snd, sndNext;
  logic               doneNext;
  logic               loadCmd;
  logic [BYTE_W-1:0]  code;

  assign code    = headEntry[BYTE_W-1:0];
  assign lkCode  = code;
  assign loadCmd = headValid && headEntry[BYTE_W];

  always_comb begin
    cmdNext  = cmd;
    ptrNext  = ptr;
    rcvNext  = rcv;
    sndNext  = snd;
    doneNext = 1'b0;
    st       = '0;
    st.pop   = headValid;
    if (loadCmd) begin
      cmdNext = code;
      if (code[6:5] == 2'b01) begin
        ptrNext = PRAM_AW'(CODE_BASE);
        sndNext = '0;
        case (code[4:3])
          2'b00:   rcvNext = CNT_W'(2);
          2'b01:   rcvNext = '0;
          default: rcvNext = CNT_W'(1);
        endcase
      end else begin
        ptrNext    = lkPtr;
        rcvNext    = lkRecv;
        sndNext    = lkSend;
        st.csrCopy = (lkSend != '0) && (lkPtr == PRAM_AW'(CSRR_BASE));
      end
    end else if (headValid && (rcv != '0)) begin
      st.ramWe   = 1'b1;
      st.ramAddr = ptr;
      st.ramData = code;
      ptrNext    = ptr + 1'b1;
      rcvNext    = rcv - 1'b1;
      doneNext   = (rcv == CNT_W'(1)) && ((cmd & 8'hE4) == 8'h20);
    end else if (rdStrobe && (snd != '0)) begin
      ptrNext = ptr + 1'b1;
      sndNext = snd - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd    <= '0;
      ptr    <= '0;
      rcv    <= '0;
      snd    <= '0;
      wrDone <= 1'b0;
    end else begin
      cmd    <= cmdNext;
      ptr    <= ptrNext;
      rcv    <= rcvNext;
      snd    <= sndNext;
      wrDone <= doneNext;
    end
  end

  assign pending = (snd != '0);
  assign rdPtr   = ptr;

  // R11
  done_last_param_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |-> ((rcv == '0) && ($past(rcv) == CNT_W'(1))));
  // R5
  rcv_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(loadCmd) |-> ((rcv == $past(rcv)) || (rcv == $past(rcv) - 1'b1)));
  // R9
  snd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(loadCmd) |-> ((snd == $past(snd)) || (snd == $past(snd) - 1'b1)));
endmodule

// File: rtl/dcq_frontend.sv
module dcq_frontend
  import dcq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 16,
  parameter int CNT_W        = 4,
  parameter int REGION_SHIFT = 3,
  parameter int CODE_BASE    = 16,
  parameter int CSRW_BASE    = 0,
  parameter int CSRR_BASE    = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWrEn,
  input  logic [7:0]          cmdData,
  input  logic                paramWrEn,
  input  logic [7:0]          paramData,
  input  logic                rdStrobe,
  output logic [7:0]          rdData,
  output logic [7:0]          statusByte,
  input  logic                hsyncIn,
  input  logic                vsyncIn,
  output logic [7:0]          lkCode,
  input  logic [PRAM_AW-1:0]  lkPtr,
  input  logic [CNT_W-1:0]    lkRecv,
  input  logic [CNT_W-1:0]    lkSend,
  output logic                wrDone,
  output logic [(1<<(PRAM_AW-REGION_SHIFT))-1:0] dirtyPulse
);
  ctlStrobeT          st;
  logic [BYTE_W:0]    headEntry;
  logic               headValid;
  logic               pending;
  logic [PRAM_AW-1:0] rdPtr;

  dcq_datapath #(
    .FIFO_DEPTH(FIFO_DEPTH), .REGION_SHIFT(REGION_SHIFT),
    .CSRW_BASE(CSRW_BASE), .CSRR_BASE(CSRR_BASE)
  ) datapath_i (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdData(cmdData),
    .paramWrEn(paramWrEn), .paramData(paramData),
    .st(st), .pending(pending), .rdPtr(rdPtr),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .headEntry(headEntry), .headValid(headValid),
    .statusByte(statusByte), .rdData(rdData), .dirtyPulse(dirtyPulse)
  );

  dcq_control #(
    .CNT_W(CNT_W), .CODE_BASE(CODE_BASE), .CSRR_BASE(CSRR_BASE)
  ) control_i (
    .clk(clk), .rstN(rstN),
    .headEntry(headEntry), .headValid(headValid), .rdStrobe(rdStrobe),
    .lkPtr(lkPtr), .lkRecv(lkRecv), .lkSend(lkSend),
    .lkCode(lkCode), .st(st), .pending(pending), .rdPtr(rdPtr),
    .wrDone(wrDone)
  );
endmodule

// File: tb/dcq_frontend_tb.sv
`timescale 1ns/1ps
module dcq_frontend_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWrEn = 1'b0, paramWrEn = 1'b0, rdStrobe = 1'b0;
  logic [7:0] cmdData = '0, paramData = '0;
  logic       hsyncIn = 1'b0, vsyncIn = 1'b0;
  logic [7:0] rdData, statusByte, lkCode;
  logic [4:0] lkPtr;
  logic [3:0] lkRecv, lkSend;
  logic       wrDone;
  logic [3:0] dirtyPulse;

  int nChecks = 0, nFails = 0;
  int doneCnt = 0;
  int dirtyCnt [4] = '{0, 0, 0, 0};
  logic [7:0] expQ [$];

  always #2.5 clk = ~clk;

  dcq_frontend dut_i (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdData(cmdData),
    .paramWrEn(paramWrEn), .paramData(paramData),
    .rdStrobe(rdStrobe), .rdData(rdData), .statusByte(statusByte),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .lkCode(lkCode), .lkPtr(lkPtr), .lkRecv(lkRecv), .lkSend(lkSend),
    .wrDone(wrDone), .dirtyPulse(dirtyPulse)
  );

  // environment command table
  always_comb begin
    lkPtr = '0; lkRecv = '0; lkSend = '0;
    case (lkCode)
      8'h49: begin lkPtr = 5'd0;  lkRecv = 4'd3; end
      8'hC8: begin lkPtr = 5'd0;  lkSend = 4'd3; end
      8'hC0: begin lkPtr = 5'd16; lkSend = 4'd2; end
      8'hE0: begin lkPtr = 5'd24; lkSend = 4'd5; end
      default: ;
    endcase
  end

  // monitor of pulses
  always @(negedge clk) if (rstN) begin
    if (wrDone) doneCnt++;
    for (int r = 0; r < 4; r++) if (dirtyPulse[r]) dirtyCnt[r]++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wrByte(bit isCmd, logic [7:0] d);
    @(negedge clk);
    if (isCmd) begin cmdWrEn = 1'b1; cmdData = d; end
    else begin paramWrEn = 1'b1; paramData = d; end
    @(negedge clk);
    cmdWrEn = 1'b0; paramWrEn = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!statusByte[2]) @(negedge clk);
  endtask

  // scoreboard consumer: pops one expected byte per strobe
  task automatic readBurst(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdStrobe = 1'b1;
      #1;
      begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(rdData == e, req, "read-back byte", rdData, e);
      end
    end
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 0 expected 1");
    finishRun();
  end

  initial begin
    int d2, dn;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 R9 reset state
    chk(statusByte == 8'h84, "R8", "reset status", statusByte, 8'h84);
    chk(rdData == 8'hFF, "R9", "idle read data", rdData, 8'hFF);
    chk(wrDone == 1'b0, "R11", "reset done", wrDone, 0);
    hsyncIn = 1'b1; #1;
    chk(statusByte == 8'hC4, "R8", "hsync status", statusByte, 8'hC4);
    hsyncIn = 1'b0; vsyncIn = 1'b1; #1;
    chk(statusByte == 8'hA4, "R8", "vsync status", statusByte, 8'hA4);
    vsyncIn = 1'b0;

    // R7 R6: cursor write via lookup, three changed bytes in region 0
    wrByte(1, 8'h49);
    wrByte(0, 8'h34); wrByte(0, 8'h12); wrByte(0, 8'h07);
    settle(); @(negedge clk);
    chk(dirtyCnt[0] == 3, "R6", "region0 pulses", dirtyCnt[0], 3);
    chk(doneCnt == 0, "R11", "no done for lookup cmd", doneCnt, 0);

    // R7 R9 dump cursor area, then idle FF
    wrByte(1, 8'hC8); settle();
    chk(statusByte == 8'h85, "R8", "pending status", statusByte, 8'h85);
    expQ.push_back(8'h34); expQ.push_back(8'h12); expQ.push_back(8'h07);
    expQ.push_back(8'hFF);
    readBurst(4, "R9");

    // R10 cursor read copy
    wrByte(1, 8'hE0); settle();
    expQ.push_back(8'h34); expQ.push_back(8'h12); expQ.push_back(8'h03);
    expQ.push_back(8'h00); expQ.push_back(8'h00); expQ.push_back(8'hFF);
    readBurst(6, "R10");

    // R4 R11 R1: memory write 0x20 with two params, latency of done
    wrByte(1, 8'h20); wrByte(0, 8'hAA); wrByte(0, 8'h55);
    chk(wrDone == 1'b0, "R1", "done before processing", wrDone, 0);
    @(negedge clk);
    chk(wrDone == 1'b1, "R1", "done one edge after push", wrDone, 1);
    @(negedge clk);
    chk(wrDone == 1'b0, "R11", "done one cycle wide", wrDone, 0);
    chk(doneCnt == 1, "R11", "done count", doneCnt, 1);
    chk(dirtyCnt[2] == 2, "R6", "region2 pulses", dirtyCnt[2], 2);
    wrByte(1, 8'hC0); settle();
    expQ.push_back(8'hAA); expQ.push_back(8'h55);
    readBurst(2, "R4");

    // R4 R5: bits 4:3 = 10 gives one byte; extra ignored
    wrByte(1, 8'h30); wrByte(0, 8'h11); wrByte(0, 8'h22); settle();
    chk(doneCnt == 2, "R11", "done after single param", doneCnt, 2);
    // R4: bits 4:3 = 01 gives none
    wrByte(1, 8'h28); wrByte(0, 8'h99); settle(); @(negedge clk);
    chk(doneCnt == 2, "R4", "no done for zero-count write", doneCnt, 2);
    wrByte(1, 8'hC0); settle();
    expQ.push_back(8'h11); expQ.push_back(8'h55);
    readBurst(2, "R5");

    // R11: 0x24 stores but no pulse
    d2 = dirtyCnt[2];
    wrByte(1, 8'h24); wrByte(0, 8'h66); wrByte(0, 8'h77); settle(); @(negedge clk);
    chk(doneCnt == 2, "R11", "no done for 0x24", doneCnt, 2);
    chk(dirtyCnt[2] == d2 + 2, "R6", "changed bytes pulse", dirtyCnt[2], d2 + 2);
    // R6: rewrite identical values
    d2 = dirtyCnt[2];
    wrByte(1, 8'h20); wrByte(0, 8'h66); wrByte(0, 8'h77); settle(); @(negedge clk);
    chk(dirtyCnt[2] == d2, "R6", "equal bytes no pulse", dirtyCnt[2], d2);
    chk(doneCnt == 3, "R11", "done on rewrite", doneCnt, 3);

    // R3: same-cycle parameter then command
    dn = doneCnt;
    wrByte(1, 8'h20);
    @(negedge clk);
    paramWrEn = 1'b1; paramData = 8'h3C; cmdWrEn = 1'b1; cmdData = 8'hC0;
    @(negedge clk);
    paramWrEn = 1'b0; cmdWrEn = 1'b0;
    settle();
    expQ.push_back(8'h3C); expQ.push_back(8'h77);
    readBurst(2, "R3");
    chk(doneCnt == dn, "R3", "command cut write short", doneCnt, dn);

    // R2: fill the queue by writing both ports every cycle
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      paramWrEn = 1'b1; paramData = 8'h00; cmdWrEn = 1'b1; cmdData = 8'h00;
    end
    @(negedge clk);
    paramWrEn = 1'b0; cmdWrEn = 1'b0;
    chk(statusByte[1] == 1'b1, "R2", "full flag", statusByte[1], 1);
    repeat (15) @(negedge clk);
    chk(statusByte[2] == 1'b0, "R2", "not empty after 15 pops", statusByte[2], 0);
    @(negedge clk);
    chk(statusByte[2] == 1'b1, "R2", "empty after 16 pops", statusByte[2], 1);
    chk(statusByte == 8'h84, "R8", "final status", statusByte, 8'h84);

    finishRun();
  end
endmodule